// File: doc/BRIEF.md
# Sync Regeneration from Data Enable

This block rebuilds active-low horizontal and vertical sync for a 720x576 progressive 50 Hz video stream whose only timing input is a one-bit data-enable flag. It sits on the pixel clock and takes an 8-bit luma sample with each clock. A free-running horizontal position counter is snapped to zero on the first active pixel of every line. A line counter is snapped to zero on the first active pixel after an idle run longer than the horizontal blanking, because only vertical blanking can be that long. The two counters are decoded into sync pulses. The outputs are a data-enable flag and a grey pixel: the luma byte copied onto the red, green and blue channels.

Pixels arrive with data enable and are presented again on the output with the same flag. Video timing cannot be paused, so the block has no ready signal and applies no back-pressure. Each input sample is consumed in the clock it appears and comes out exactly two clocks later. The sync outputs are aligned with that delayed pixel. The default parameters describe an 864-clock line, with a sync window at positions 732 to 795 and 720 active pixels. A frame has 625 lines, with vertical sync on lines 581 to 585. All these values are parameters.

Top module: `de_sync_rebuild`

## Requirements
- R1: While reset is high, and afterwards until the horizontal position first reaches HS_START, `hsync_n_o` and `vsync_n_o` are high and `de_o` is low. Reset clears both counters.
- R2: With no active data, the horizontal position counts from 0 to H_TOTAL-1 and wraps, so falling edges of `hsync_n_o` are H_TOTAL clocks apart.
- R3: `hsync_n_o` is low exactly while the horizontal position lies in HS_START..HS_END, which gives a low time of HS_END-HS_START+1 clocks.
- R4: A rising edge of `de_i` (the first active pixel of a line) forces the horizontal position to 0. `hsync_n_o` then falls HS_START clocks after that pixel leaves on `de_o` (732 with default parameters).
- R5: A rising edge of `de_i` that follows more than IDLE_LIMIT = H_TOTAL-H_ACTIVE consecutive idle clocks (144 by default) resets the line counter to 0. `vsync_n_o` then falls VS_START*H_TOTAL clocks after that pixel leaves on `de_o`.
- R6: A rising edge of `de_i` after exactly IDLE_LIMIT idle clocks does not reset the line counter, so one vsync pulse still appears per frame of back-to-back lines.
- R7: The line counter advances by one each time the horizontal position wraps from H_TOTAL-1 to 0. From reset with no data, `vsync_n_o` falls VS_START*H_TOTAL-HS_START clocks after the first fall of `hsync_n_o`.
- R8: If no realignment arrives, the line counter stops at V_TOTAL-1. After reset with no data, exactly one vsync pulse occurs.
- R9: `de_o` repeats `de_i` two clocks later, and `red_o`, `grn_o` and `blu_o` each carry the luma value of that same sample.
- R10: `vsync_n_o` stays low for (VS_END-VS_START+1)*H_TOTAL clocks (line counter in VS_START..VS_END).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| de_i | input | 1 | Active-pixel flag for the incoming sample |
| luma_i | input | DATA_W | Luma sample |
| hsync_n_o | output | 1 | Regenerated horizontal sync, active low |
| vsync_n_o | output | 1 | Regenerated vertical sync, active low |
| de_o | output | 1 | Data enable aligned with the sync outputs |
| red_o | output | DATA_W | Red channel (copy of luma) |
| grn_o | output | DATA_W | Green channel (copy of luma) |
| blu_o | output | DATA_W | Blue channel (copy of luma) |

## Verification
The bench targets the boundary between horizontal and vertical blanking. Gaps of exactly IDLE_LIMIT clocks occur between lines, and one line is delayed by a single clock. A design that compares the idle run with the wrong inclusive bound would either reset the line counter on every line, so vsync would never appear, or would miss the delayed-line realignment, so vsync would land one offset too late. A stretch of idle frames straight after reset checks that the line counter parks at its last value. A wrapping counter there would produce a second vsync pulse. Pulse widths, pulse offsets from the first output pixel and the two-clock pixel delay are all measured at the ports. An off-by-one in the pipeline would shift every offset, and a wrong sync window would change the pulse widths.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int unsigned PIX_CHANNELS = 3;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/drs_hcount.sv
module drs_hcount #(
  parameter int unsigned H_TOTAL = 864,
  parameter int unsigned HW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_i,
  output logic          rise_o,
  output logic          wrap_o,
  output logic [HW-1:0] h_cnt_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

  logic de_q;

  always_ff @(posedge clk) begin
    if (rst) de_q <= 1'b0;
    else     de_q <= de_i;
  end

  assign rise_o = de_i & ~de_q;
  assign wrap_o = (h_cnt_o == H_LAST);

  always_ff @(posedge clk) begin
    if (rst)                  h_cnt_o <= '0;
    else if (rise_o || wrap_o) h_cnt_o <= '0;
    else                      h_cnt_o <= h_cnt_o + HW'(1);
  end

  // R2: position never leaves the line
  a_r2_in_line: assert property (@(posedge clk) disable iff (rst) h_cnt_o <= H_LAST);
  // R2: free running step between realignments
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!rise_o && !wrap_o) |=> (h_cnt_o == $past(h_cnt_o) + HW'(1)));
  // R2: wrap returns to zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (rst) wrap_o |=> (h_cnt_o == '0));
  // R4: first active pixel forces the position to zero
  a_r4_first_pixel: assert property (@(posedge clk) disable iff (rst) rise_o |=> (h_cnt_o == '0));
endmodule

// File: rtl/drs_vcount.sv
module drs_vcount #(
  parameter int unsigned V_TOTAL    = 625,
  parameter int unsigned IDLE_LIMIT = 144,
  parameter int unsigned VW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          de_i,
  input  logic          rise_i,
  input  logic          wrap_i,
  output logic [VW-1:0] v_cnt_o
);
  localparam int unsigned    IW       = drs_pkg::cnt_w(IDLE_LIMIT + 2);
  localparam logic [IW-1:0]  IDLE_SAT = IW'(IDLE_LIMIT + 1);
  localparam logic [VW-1:0]  V_LAST   = VW'(V_TOTAL - 1);

  logic [IW-1:0] idle_cnt;
  logic          realign;

  // Counts consecutive idle clocks; parks once the run is longer than IDLE_LIMIT
  always_ff @(posedge clk) begin
    if (rst)                    idle_cnt <= '0;
    else if (de_i)              idle_cnt <= '0;
    else if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + IW'(1);
  end

  assign realign = rise_i && (idle_cnt == IDLE_SAT);

  always_ff @(posedge clk) begin
    if (rst)                          v_cnt_o <= '0;
    else if (realign)                 v_cnt_o <= '0;
    else if (wrap_i && v_cnt_o != V_LAST) v_cnt_o <= v_cnt_o + VW'(1);
  end

  // R8: line counter bounded by the frame
  a_r8_line_cap: assert property (@(posedge clk) disable iff (rst) v_cnt_o <= V_LAST);
  // R8: parked at the last line without realignment
  a_r8_hold_last: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && !realign && v_cnt_o == V_LAST) |=> (v_cnt_o == V_LAST));
  // R5: long gap followed by a pixel restarts the frame
  a_r5_realign_zero: assert property (@(posedge clk) disable iff (rst) realign |=> (v_cnt_o == '0));
  // R6: a short gap leaves the line count alone
  a_r6_short_gap: assert property (@(posedge clk) disable iff (rst)
    (rise_i && !realign && !wrap_i) |=> $stable(v_cnt_o));
  // R6: idle run never exceeds its parking value
  a_r6_idle_bound: assert property (@(posedge clk) disable iff (rst) idle_cnt <= IDLE_SAT);
  // R7: one line per horizontal wrap
  a_r7_line_step: assert property (@(posedge clk) disable iff (rst)
    (wrap_i && !realign && v_cnt_o != V_LAST) |=> (v_cnt_o == $past(v_cnt_o) + VW'(1)));
endmodule

// File: rtl/drs_outstage.sv
module drs_outstage #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HW       = 10,
  parameter int unsigned VW       = 10,
  parameter int unsigned HS_START = 732,
  parameter int unsigned HS_END   = 795,
  parameter int unsigned VS_START = 581,
  parameter int unsigned VS_END   = 585
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      de_i,
  input  logic [DATA_W-1:0]                         luma_i,
  input  logic [HW-1:0]                             h_cnt_i,
  input  logic [VW-1:0]                             v_cnt_i,
  output logic                                      hsync_n_o,
  output logic                                      vsync_n_o,
  output logic                                      de_o,
  output logic [drs_pkg::PIX_CHANNELS*DATA_W-1:0]   rgb_o
);
  localparam int unsigned NCH = drs_pkg::PIX_CHANNELS;

  logic              de_d1;
  logic [DATA_W-1:0] luma_d1;
  logic [DATA_W-1:0] luma_q;
  logic              hs_win;
  logic              vs_win;

  // Stage 1: sample lines up with the counter value it produced
  always_ff @(posedge clk) begin
    if (rst) begin
      de_d1   <= 1'b0;
      luma_d1 <= '0;
    end else begin
      de_d1   <= de_i;
      luma_d1 <= luma_i;
    end
  end

  assign hs_win = (h_cnt_i >= HW'(HS_START)) && (h_cnt_i <= HW'(HS_END));
  assign vs_win = (v_cnt_i >= VW'(VS_START)) && (v_cnt_i <= VW'(VS_END));

  // Stage 2: all outputs registered together
  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
      de_o      <= 1'b0;
      luma_q    <= '0;
    end else begin
      hsync_n_o <= ~hs_win;
      vsync_n_o <= ~vs_win;
      de_o      <= de_d1;
      luma_q    <= luma_d1;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign rgb_o[ch*DATA_W +: DATA_W] = luma_q;
  end

  // R1: first cycle after reset shows idle outputs
  a_r1_reset_idle: assert property (@(posedge clk) $past(rst) |-> (hsync_n_o && vsync_n_o && !de_o));
  // R9: output pixel is the input sample two clocks back
  a_r9_de_delay: assert property (@(posedge clk) disable iff (rst) de_o |-> $past(de_i, 2));
  a_r9_luma_delay: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (rgb_o[DATA_W-1:0] == $past(luma_i, 2)));
endmodule

// File: rtl/de_sync_rebuild.sv
module de_sync_rebuild #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned H_TOTAL  = 864,
  parameter int unsigned H_ACTIVE = 720,
  parameter int unsigned HS_START = 732,
  parameter int unsigned HS_END   = 795,
  parameter int unsigned V_TOTAL  = 625,
  parameter int unsigned VS_START = 581,
  parameter int unsigned VS_END   = 585
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de_i,
  input  logic [DATA_W-1:0] luma_i,
  output logic              hsync_n_o,
  output logic              vsync_n_o,
  output logic              de_o,
  output logic [DATA_W-1:0] red_o,
  output logic [DATA_W-1:0] grn_o,
  output logic [DATA_W-1:0] blu_o
);
  localparam int unsigned IDLE_LIMIT = H_TOTAL - H_ACTIVE;
  localparam int unsigned HW         = drs_pkg::cnt_w(H_TOTAL);
  localparam int unsigned VW         = drs_pkg::cnt_w(V_TOTAL);
  localparam int unsigned NCH        = drs_pkg::PIX_CHANNELS;

  logic                    rise;
  logic                    wrap;
  logic [HW-1:0]           h_cnt;
  logic [VW-1:0]           v_cnt;
  logic [NCH*DATA_W-1:0]   rgb;

  drs_hcount #(.H_TOTAL(H_TOTAL), .HW(HW)) u_hcount (
    .clk     (clk),
    .rst     (rst),
    .de_i    (de_i),
    .rise_o  (rise),
    .wrap_o  (wrap),
    .h_cnt_o (h_cnt)
  );

  drs_vcount #(.V_TOTAL(V_TOTAL), .IDLE_LIMIT(IDLE_LIMIT), .VW(VW)) u_vcount (
    .clk     (clk),
    .rst     (rst),
    .de_i    (de_i),
    .rise_i  (rise),
    .wrap_i  (wrap),
    .v_cnt_o (v_cnt)
  );

  drs_outstage #(
    .DATA_W(DATA_W), .HW(HW), .VW(VW),
    .HS_START(HS_START), .HS_END(HS_END),
    .VS_START(VS_START), .VS_END(VS_END)
  ) u_out (
    .clk       (clk),
    .rst       (rst),
    .de_i      (de_i),
    .luma_i    (luma_i),
    .h_cnt_i   (h_cnt),
    .v_cnt_i   (v_cnt),
    .hsync_n_o (hsync_n_o),
    .vsync_n_o (vsync_n_o),
    .de_o      (de_o),
    .rgb_o     (rgb)
  );

  assign red_o = rgb[0*DATA_W +: DATA_W];
  assign grn_o = rgb[1*DATA_W +: DATA_W];
  assign blu_o = rgb[2*DATA_W +: DATA_W];
endmodule

// File: tb/test_de_sync_rebuild.sv
module test_de_sync_rebuild;
  localparam int DW = 8, HT = 32, HA = 24, HSS = 26, HSE = 29;
  localparam int VT = 12, VSS = 9, VSE = 10, VA = 6;
  localparam int IDLE = HT - HA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic de = 1'b0;
  logic [DW-1:0] luma = '0;
  logic hs_n, vs_n, de_o;
  logic [DW-1:0] r, g, b;

  logic de_f = 1'b0;
  logic [7:0] luma_f = '0;
  logic hsf_n, vsf_n, def_o;
  logic [7:0] rf, gf, bf;

  always #5 clk = ~clk;

  de_sync_rebuild #(
    .DATA_W(DW), .H_TOTAL(HT), .H_ACTIVE(HA), .HS_START(HSS), .HS_END(HSE),
    .V_TOTAL(VT), .VS_START(VSS), .VS_END(VSE)
  ) i_de_sync_rebuild (
    .clk(clk), .rst(rst), .de_i(de), .luma_i(luma),
    .hsync_n_o(hs_n), .vsync_n_o(vs_n), .de_o(de_o),
    .red_o(r), .grn_o(g), .blu_o(b)
  );

  de_sync_rebuild i_de_sync_rebuild_full (
    .clk(clk), .rst(rst), .de_i(de_f), .luma_i(luma_f),
    .hsync_n_o(hsf_n), .vsync_n_o(vsf_n), .de_o(def_o),
    .red_o(rf), .grn_o(gf), .blu_o(bf)
  );

  int n_tests = 0, n_fail = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard of expected pixels
  logic [DW-1:0] px_q[$];

  // monitor state
  int     rel_cnt = 0, r1_bad = 0, out_idle = 1000, vs_fall_cnt = 0;
  bit     prev_de = 0, prev_hs = 1, prev_vs = 1, rise_pend = 0, fs_pend = 0;
  longint last_rise = -1, frame_start = -1, prev_hs_fall = -1, first_hs_fall = -1;
  longint hs_low_start = 0, vs_low_start = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (rel_cnt < HSS) begin
        if (!hs_n || !vs_n) r1_bad++;
      end else if (rel_cnt == HSS) check_eq("R1", "sync stayed idle after reset", r1_bad, 0);
      rel_cnt++;

      if (de_o && !prev_de) begin
        last_rise = cyc;
        rise_pend = 1;
        if (out_idle > IDLE) begin frame_start = cyc; fs_pend = 1; end
      end
      if (de_o) begin
        out_idle = 0;
        if (px_q.size() == 0) check_eq("R9", "unexpected output pixel", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = px_q.pop_front();
          check_eq("R9", "rgb copy of luma", {r, g, b}, {e, e, e});
        end
      end else out_idle++;

      if (!hs_n && prev_hs) begin
        if (rise_pend) check_eq("R4", "hsync offset from first pixel", cyc - last_rise, HSS);
        else if (prev_hs_fall >= 0) check_eq("R2", "hsync period", cyc - prev_hs_fall, HT);
        if (first_hs_fall < 0) first_hs_fall = cyc;
        prev_hs_fall = cyc;
        rise_pend = 0;
        hs_low_start = cyc;
      end
      if (hs_n && !prev_hs && last_rise != cyc)
        check_eq("R3", "hsync low width", cyc - hs_low_start, HSE - HSS + 1);

      if (!vs_n && prev_vs) begin
        vs_fall_cnt++;
        vs_low_start = cyc;
        if (fs_pend) begin
          check_eq("R5", "vsync offset from frame start", cyc - frame_start, VSS * HT);
          fs_pend = 0;
        end else if (vs_fall_cnt == 1)
          check_eq("R7", "vsync offset from first hsync", cyc - first_hs_fall, VSS * HT - HSS);
        else check_eq("R8", "vsync without realignment", 1, 0);
      end
      if (vs_n && !prev_vs)
        check_eq("R10", "vsync low width", cyc - vs_low_start, (VSE - VSS + 1) * HT);

      prev_de = de_o;
      prev_hs = hs_n;
      prev_vs = vs_n;
    end
  end

  // monitor for the default-size instance
  bit prev_def = 0, prev_hsf = 1, f_armed = 0;
  int f_checked = 0;
  longint f_rise = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (def_o && !prev_def) begin f_rise = cyc; f_armed = 1; end
      if (!hsf_n && prev_hsf && f_armed) begin
        check_eq("R4", "default-size hsync offset", cyc - f_rise, 732);
        f_armed = 0;
        f_checked++;
      end
      prev_def = def_o;
      prev_hsf = hsf_n;
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      de <= 1'b0;
      luma <= '0;
    end
  endtask

  task automatic drive_frame(input int f, input int shift_line);
    for (int ln = 0; ln < VA; ln++) begin
      if (ln == shift_line) idle(1);
      for (int p = 0; p < HA; p++) begin
        logic [DW-1:0] v;
        v = DW'(f * 37 + ln * 11 + p * 3 + 1);
        @(negedge clk);
        de <= 1'b1;
        luma <= v;
        px_q.push_back(v);
      end
      idle(IDLE);
    end
    idle((VT - VA) * HT);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    check_eq("R1", "hsync_n during reset", hs_n, 1);
    check_eq("R1", "vsync_n during reset", vs_n, 1);
    check_eq("R1", "de_o during reset", de_o, 0);
    @(negedge clk) rst <= 1'b0;
    // no data: free-running line counter must park
    idle(3 * VT * HT);
    check_eq("R8", "vsync pulses with no data", vs_fall_cnt, 1);
    // back-to-back lines with gaps of exactly IDLE clocks
    for (int f = 0; f < 3; f++) begin
      drive_frame(f, -1);
      check_eq("R6", "one vsync per frame", vs_fall_cnt, f + 2);
    end
    // a line delayed by one clock: gap of IDLE+1 realigns
    drive_frame(3, 3);
    idle(4 * HT);
    check_eq("R5", "total vsync pulses", vs_fall_cnt, 5);
    check_eq("R9", "pixels left in scoreboard", px_q.size(), 0);
    // default-size instance: one active line
    @(negedge clk) de_f <= 1'b1;
    repeat (720) @(negedge clk);
    de_f <= 1'b0;
    repeat (900) @(negedge clk);
    check_eq("R4", "default-size hsync observed", f_checked, 1);
  endtask

  bit wd = 0;
  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) begin
      n_tests++;
      n_fail++;
      $display("FAIL all requirements watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule